// File: doc/BRIEF.md
# SIMD Lane Activity Mask Controller

This block keeps the activity bits for a row of processing lanes that all receive one broadcast operation. Every lane owns two activity bits, one for its lower 32-bit half and one for its upper 32-bit half, so the row can act either as full-width lanes or as twice as many half-width lanes. A lane half whose bit is 1 executes the broadcast operation. A lane half whose bit is 0 skips it and keeps its state. The two bit vectors drive the per-half execute enables `lane_en_lo` and `lane_en_hi` directly.

The scalar controller issues one command per accepted handshake on the command stream. Half-selectable commands are: write the bits from per-lane compare results, invert the bits, and load the bits from a scalar accumulator word in which bit i belongs to lane i. A separate command forces every bit on. Two commands produce a result on the response stream. Read-back copies the activity bits into an accumulator-sized word. First-active scans an accumulator word from bit 0 upward and returns the position of the lowest set bit, together with a flag for an all-zero word.

Mask updates appear on the enables in the cycle after the command is accepted. A response appears in the cycle after its command is accepted and stays there until the consumer takes it. While an untaken response is held, the block refuses new commands. Data exchange between lanes is not gated by these bits and lies outside this block.

Top module: `lane_mode_ctrl`

## Requirements
- R1: After reset every lower-half and upper-half activity bit is 1, and `rsp_valid` is 0.
- R2: Compare write (`cmd_op`=1): for each half selected in `cmd_half` (bit 0 lower, bit 1 upper), lane i's bit takes `cmp_lo[i]` or `cmp_hi[i]` one cycle after acceptance. Unselected halves keep their bits.
- R3: Invert (`cmd_op`=2): every bit of each selected half flips one cycle after acceptance. Unselected halves keep their bits.
- R4: All-on (`cmd_op`=3): every bit of both halves becomes 1 one cycle after acceptance, whatever the value of `cmd_half`.
- R5: Load (`cmd_op`=4): for each selected half, lane i's bit takes `cmd_acc[i]` one cycle after acceptance.
- R6: Read-back (`cmd_op`=5): one cycle after acceptance `rsp_valid` is 1 and `rsp_data[i]` = (`cmd_half[0]` AND lower bit i) OR (`cmd_half[1]` AND upper bit i), using the bits as they were when the command was accepted. `rsp_none` is 0.
- R7: First-active (`cmd_op`=6): one cycle after acceptance `rsp_valid` is 1. `rsp_data` holds the index of the lowest set bit of `cmd_acc`, zero-extended, and `rsp_none` is 0. If `cmd_acc` is zero, `rsp_data` is 0 and `rsp_none` is 1.
- R8: `cmd_ready` = NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` and `rsp_none` hold their values. A command that is not accepted changes no activity bit.
- R9: No-op (`cmd_op`=0), the reserved code 7, and the half-selectable commands issued with `cmd_half`=0 leave every activity bit unchanged. Read-back and first-active also leave every activity bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code (0 nop, 1 compare write, 2 invert, 3 all-on, 4 load, 5 read-back, 6 first-active) |
| cmd_half | input | 2 | Half select: bit 0 lower halves, bit 1 upper halves |
| cmd_acc | input | LANES | Scalar accumulator word, bit i for lane i |
| cmp_lo | input | LANES | Per-lane compare results for the lower halves |
| cmp_hi | input | LANES | Per-lane compare results for the upper halves |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | LANES | Read-back word or first-active index |
| rsp_none | output | 1 | First-active found no set bit |
| lane_en_lo | output | LANES | Execute enables for the lower halves |
| lane_en_hi | output | LANES | Execute enables for the upper halves |

## Verification
Two things can happen in the same cycle here. A held response can drain through `rsp_ready` while a new command is accepted, and a read-back can be accepted in the same cycle as a mask-changing command that came just before it. The random stream toggles `rsp_ready` independently of `cmd_valid`, so a response handover and a new mask update often fall on the same edge. Directed cases stall a read-back under back-pressure while further commands wait. For each case the bench model checks that the response keeps the mask value from its acceptance cycle, that stalled commands leave the mask alone, and that the draining cycle accepts the next command.

// File: rtl/lane_mode_pkg.sv
package lane_mode_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CMP   = 3'd1,
    OP_FLIP  = 3'd2,
    OP_ALLON = 3'd3,
    OP_LOAD  = 3'd4,
    OP_READ  = 3'd5,
    OP_FIRST = 3'd6,
    OP_RSV   = 3'd7
  } mode_op_e;

  localparam int unsigned HALVES = 2;
endpackage

// File: rtl/half_mask_bank.sv
module half_mask_bank #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_all,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         flip,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '1;
    else if (set_all) mask <= '1;
    else if (wr_en)   mask <= wr_val;
    else if (flip)    mask <= ~mask;
  end

  AST_ALLON_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    set_all |=> (mask == '1)); // R4
  AST_FLIP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !set_all && !wr_en) |=> (mask == ~$past(mask))); // R3
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_all) |=> (mask == $past(wr_val))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_all || wr_en || flip) |=> $stable(mask)); // R9
endmodule

// File: rtl/low_first_one.sv
module low_first_one #(
  parameter int unsigned W  = 64,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx  = IW'(i);
        none = 1'b0;
      end
    end
  end

  always_comb begin
    if (!none) begin
      AST_IDX_IS_SET: assert (vec[idx]); // R7
    end else begin
      AST_NONE_MEANS_ZERO: assert (vec == '0 && idx == '0); // R7
    end
  end
endmodule

// File: rtl/lane_mode_ctrl.sv
module lane_mode_ctrl
  import lane_mode_pkg::*;
#(
  parameter int unsigned LANES = 64,
  localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [1:0]       cmd_half,
  input  logic [LANES-1:0] cmd_acc,
  input  logic [LANES-1:0] cmp_lo,
  input  logic [LANES-1:0] cmp_hi,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [LANES-1:0] rsp_data,
  output logic             rsp_none,
  output logic [LANES-1:0] lane_en_lo,
  output logic [LANES-1:0] lane_en_hi
);
  mode_op_e         op;
  logic             accept;
  logic [LANES-1:0] cmp_v  [HALVES];
  logic [LANES-1:0] mask_v [HALVES];
  logic [LANES-1:0] readback;
  logic [IW-1:0]    first_idx;
  logic             first_none;

  assign op        = mode_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign cmp_v[0]  = cmp_lo;
  assign cmp_v[1]  = cmp_hi;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic sel;
    logic wr_en;
    logic [LANES-1:0] wr_val;
    assign sel    = accept && cmd_half[h];
    assign wr_en  = sel && (op == OP_CMP || op == OP_LOAD);
    assign wr_val = (op == OP_LOAD) ? cmd_acc : cmp_v[h];

    half_mask_bank #(.W(LANES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_all (accept && op == OP_ALLON),
      .wr_en   (wr_en),
      .wr_val  (wr_val),
      .flip    (sel && op == OP_FLIP),
      .mask    (mask_v[h])
    );
  end

  assign lane_en_lo = mask_v[0];
  assign lane_en_hi = mask_v[1];

  always_comb begin
    readback = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (cmd_half[h]) readback = readback | mask_v[h];
    end
  end

  low_first_one #(.W(LANES)) u_first (
    .vec  (cmd_acc),
    .idx  (first_idx),
    .none (first_none)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_none  <= 1'b0;
    end else if (accept && (op == OP_READ || op == OP_FIRST)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (op == OP_READ) ? readback : LANES'(first_idx);
      rsp_none  <= (op == OP_FIRST) && first_none;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_none))); // R8
  AST_STALL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(lane_en_lo) && $stable(lane_en_hi))); // R8
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_READ || op == OP_FIRST)) |=> rsp_valid); // R6
  AST_READ_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_READ && cmd_half == 2'b01) |=> (rsp_data == $past(lane_en_lo) && !rsp_none)); // R6
endmodule

// File: tb/lane_mode_ctrl_test.sv
module lane_mode_ctrl_test;
  localparam int L = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_half;
  logic [L-1:0] cmd_acc, cmp_lo, cmp_hi;
  logic         rsp_valid, rsp_ready, rsp_none;
  logic [L-1:0] rsp_data, lane_en_lo, lane_en_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [L-1:0] m_lo, m_hi, e_data;
  logic         e_rv, e_none;
  string        tag;
  string        rtag;

  always #4 clk = ~clk;

  lane_mode_ctrl #(.LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_half(cmd_half), .cmd_acc(cmd_acc), .cmp_lo(cmp_lo),
    .cmp_hi(cmp_hi), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_none(rsp_none), .lane_en_lo(lane_en_lo),
    .lane_en_hi(lane_en_hi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [L-1:0] low_idx(input logic [L-1:0] v);
    for (int i = 0; i < L; i++) if (v[i]) return L'(i);
    return '0;
  endfunction

  // One cycle: drive at negedge, check outputs, then advance the model.
  task automatic cyc(input bit v, input logic [2:0] op, input logic [1:0] hs,
                     input logic [L-1:0] acc, input logic [L-1:0] clo,
                     input logic [L-1:0] chi, input bit rr);
    bit acc_ok;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_half = hs; cmd_acc = acc;
    cmp_lo = clo; cmp_hi = chi; rsp_ready = rr;
    #1;
    chk(lane_en_lo == m_lo, tag, "lane_en_lo", lane_en_lo, m_lo);
    chk(lane_en_hi == m_hi, tag, "lane_en_hi", lane_en_hi, m_hi);
    chk(rsp_valid == e_rv, "R8", "rsp_valid", L'(rsp_valid), L'(e_rv));
    if (e_rv) begin
      chk(rsp_data == e_data, rtag, "rsp_data", rsp_data, e_data);
      chk(rsp_none == e_none, rtag, "rsp_none", L'(rsp_none), L'(e_none));
    end
    chk(cmd_ready == (!e_rv || rr), "R8", "cmd_ready", L'(cmd_ready), L'(!e_rv || rr));
    acc_ok = v && (!e_rv || rr);
    if (e_rv && rr) e_rv = 1'b0;
    if (!acc_ok) tag = "R8";
    else begin
      case (op)
        3'd1: begin
          if (hs[0]) m_lo = clo;
          if (hs[1]) m_hi = chi;
          tag = (hs == 2'b00) ? "R9" : "R2";
        end
        3'd2: begin
          if (hs[0]) m_lo = ~m_lo;
          if (hs[1]) m_hi = ~m_hi;
          tag = (hs == 2'b00) ? "R9" : "R3";
        end
        3'd3: begin m_lo = '1; m_hi = '1; tag = "R4"; end
        3'd4: begin
          if (hs[0]) m_lo = acc;
          if (hs[1]) m_hi = acc;
          tag = (hs == 2'b00) ? "R9" : "R5";
        end
        3'd5: begin
          e_rv = 1'b1; e_none = 1'b0; rtag = "R6"; tag = "R9";
          e_data = (hs[0] ? m_lo : '0) | (hs[1] ? m_hi : '0);
        end
        3'd6: begin
          e_rv = 1'b1; rtag = "R7"; tag = "R9";
          e_data = low_idx(acc); e_none = (acc == '0);
        end
        default: tag = "R9";
      endcase
    end
  endtask

  function automatic logic [L-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_half = 0;
    cmd_acc = '0; cmp_lo = '0; cmp_hi = '0; rsp_ready = 0;
    m_lo = '1; m_hi = '1; e_rv = 0; e_data = '0; e_none = 0;
    tag = "R1"; rtag = "R6";
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(lane_en_lo == '1, "R1", "reset lo", lane_en_lo, '1);
    chk(lane_en_hi == '1, "R1", "reset hi", lane_en_hi, '1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", L'(rsp_valid), '0);

    // Directed corners
    cyc(1, 3'd1, 2'b01, '0, 64'h00FF_00FF_00FF_00FF, '0, 1);       // R2 lower only
    cyc(1, 3'd2, 2'b10, '0, '0, '0, 1);                            // R3 upper only
    cyc(1, 3'd4, 2'b11, 64'hDEAD_BEEF_0123_4567, '0, '0, 1);       // R5
    cyc(1, 3'd2, 2'b00, '0, '0, '0, 1);                            // R9
    cyc(1, 3'd0, 2'b11, '1, '0, '0, 1);                            // R9
    cyc(1, 3'd7, 2'b11, '1, '1, '1, 1);                            // R9
    cyc(1, 3'd6, 2'b00, '0, '0, '0, 1);                            // R7 none
    cyc(1, 3'd6, 2'b00, 64'h8000_0000_0000_0000, '0, '0, 1);       // R7 top bit
    cyc(1, 3'd6, 2'b00, 64'hF000_0000_0000_0011, '0, '0, 1);       // R7 bit 0
    // R8: read held under back-pressure, stalled commands leave mask alone
    cyc(1, 3'd5, 2'b01, '0, '0, '0, 0);
    cyc(1, 3'd3, 2'b11, '0, '0, '0, 0);
    cyc(1, 3'd4, 2'b11, '0, '0, '0, 0);
    cyc(1, 3'd2, 2'b11, '0, '0, '0, 1);                            // drains and accepts
    cyc(1, 3'd5, 2'b11, '0, '0, '0, 1);                            // R6 OR of halves
    cyc(1, 3'd3, 2'b00, '0, '0, '0, 1);                            // R4 ignores half
    cyc(0, 3'd0, 2'b00, '0, '0, '0, 1);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      cyc(($urandom_range(0, 3) != 0), op, 2'($urandom_range(0, 3)),
          ($urandom_range(0, 7) == 0) ? '0 : rnd64(), rnd64(), rnd64(),
          ($urandom_range(0, 2) != 0));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule